// File: doc/BRIEF.md
# Programmable Sensor Clock Synthesizer

This block derives a slow, sensor-side clock level from the system clock. The divided waveform is set by one 32-bit control word. The word holds a low-phase count, a high-phase count and a hold count, each 8 bits wide, plus an enable bit. Software picks the counts for the frequency ratio it needs and writes the word through a single-cycle write port. The block then produces a clock-level signal and a one-cycle tick that marks each rising edge of that signal.

Each phase is programmed separately, and each lasts one cycle longer than its count. A period therefore always has an offset of two on top of the two counts. A written word is first captured into a shadow register. It moves into the active set only when the current period finishes, so a phase is never cut short. While the block is disabled, the shadow is copied every cycle, which lets an enable take effect almost at once. The hold count does not shape the waveform. It is passed on to a downstream sampling stage.

Top module: `sensor_clk_synth`

## Requirements
- R1: Control word layout: low count in bits [7:0], high count in bits [15:8], hold count in bits [23:16], enable in bit 24 (1 = run). Bits [31:25] are ignored.
- R2: While enabled, `sclk_o` stays low for low+1 system cycles and then high for high+1 system cycles, giving a period of low+high+2 cycles. This holds for any pair of counts, including unequal ones.
- R3: With key = ratio-2, low = (key+1)>>1 and high = key>>1, the period is exactly key+2 cycles. Every ratio from 2 up to 512 can be reached.
- R4: `rise_o` is high for exactly one cycle, in the same cycle in which `sclk_o` first reads high after being low, and at no other time.
- R5: While the active enable is 0, `sclk_o` is low, `rise_o` never pulses and the phase counter is held at its start. A word that sets the enable from idle, captured on clock edge E, makes `sclk_o` rise on edge E+low+2.
- R6: A word written while running takes effect only at the end of the current period. Every completed low or high phase has the full length of either the old setting or the new one.
- R7: `hold_o` shows the hold count of the active word. The hold count has no effect on the period.
- R8: After reset, `sclk_o`, `rise_o` and `hold_o` are 0 and the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word written when `cfg_we` is high |
| sclk_o | output | 1 | Divided clock-level signal |
| rise_o | output | 1 | One-cycle pulse on each rising edge of `sclk_o` |
| hold_o | output | 8 | Hold count of the active word |

## Verification
The bench sweeps every key from 0 to 47, then tries lopsided count pairs and the largest ratio. An off-by-one in the phase compare would show up there as a period one cycle long or short, and a swapped field as a wrong duty.

Words are written in the middle of both a high phase and a low phase, and every completed phase is watched. A design that reloads on the spot would leave a truncated phase of a length that belongs to neither setting.

The bench also counts the exact cycle of the first rising edge after enabling from idle, and checks that a disable leaves the output quiet with no stray tick. A tick that is late by one register, or doubled, would break the per-cycle tick-versus-edge check.

// File: rtl/sck_pkg.sv
package sck_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } sck_phase_e;

  // Bit position of a field inside the control word, given the field width.
  function automatic int fld_lsb(input int idx, input int w);
    return idx * w;
  endfunction

endpackage

// File: rtl/sck_cfg_reg.sv
module sck_cfg_reg #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              period_end,
  output logic [CNT_W-1:0]  act_lo,
  output logic [CNT_W-1:0]  act_hi,
  output logic [CNT_W-1:0]  act_hold,
  output logic              act_en
);
  import sck_pkg::*;

  localparam int LO_LSB   = fld_lsb(0, CNT_W);
  localparam int HI_LSB   = fld_lsb(1, CNT_W);
  localparam int HOLD_LSB = fld_lsb(2, CNT_W);
  localparam int EN_POS   = fld_lsb(3, CNT_W);

  logic [CNT_W-1:0] sh_lo, sh_hi, sh_hold;
  logic             sh_en;
  logic             take;

  // Shadow stage: captures every write, no effect on the waveform yet.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_lo   <= '0;
      sh_hi   <= '0;
      sh_hold <= '0;
      sh_en   <= 1'b0;
    end else if (wr_en) begin
      sh_lo   <= wr_data[LO_LSB   +: CNT_W];
      sh_hi   <= wr_data[HI_LSB   +: CNT_W];
      sh_hold <= wr_data[HOLD_LSB +: CNT_W];
      sh_en   <= wr_data[EN_POS];
    end
  end

  // Active stage: follows shadow while idle, else only at a period boundary.
  assign take = !act_en || period_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_lo   <= '0;
      act_hi   <= '0;
      act_hold <= '0;
      act_en   <= 1'b0;
    end else if (take) begin
      act_lo   <= sh_lo;
      act_hi   <= sh_hi;
      act_hold <= sh_hold;
      act_en   <= sh_en;
    end
  end

  AST_RELOAD_AT_END: assert property (@(posedge clk) disable iff (rst)
    (act_en && !period_end) |=> ($stable(act_lo) && $stable(act_hi) && $stable(act_en))); // R6

  AST_HOLD_AT_END: assert property (@(posedge clk) disable iff (rst)
    (act_en && !period_end) |=> $stable(act_hold)); // R7

endmodule

// File: rtl/sck_phase_ctr.sv
module sck_phase_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] lo,
  input  logic [CNT_W-1:0] hi,
  output logic             sclk,
  output logic             tick,
  output logic             period_end
);
  import sck_pkg::*;

  sck_phase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic             lo_done, hi_done;

  assign lo_done    = (phase == PH_LOW)  && (cnt == lo);
  assign hi_done    = (phase == PH_HIGH) && (cnt == hi);
  assign period_end = en && hi_done;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase <= PH_LOW;
      cnt   <= '0;
      tick  <= 1'b0;
    end else if (lo_done) begin
      phase <= PH_HIGH;
      cnt   <= '0;
      tick  <= 1'b1;
    end else if (hi_done) begin
      phase <= PH_LOW;
      cnt   <= '0;
      tick  <= 1'b0;
    end else begin
      cnt   <= cnt + 1'b1;
      tick  <= 1'b0;
    end
  end

  assign sclk = (phase == PH_HIGH);

  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOW) |-> (cnt <= lo)); // R2

  AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HIGH) |-> (cnt <= hi)); // R2

  AST_IDLE_RESET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (phase == PH_LOW && cnt == '0 && !tick)); // R5

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R4

endmodule

// File: rtl/sensor_clk_synth.sv
module sensor_clk_synth #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic              sclk_o,
  output logic              rise_o,
  output logic [CNT_W-1:0]  hold_o
);

  logic [CNT_W-1:0] act_lo, act_hi, act_hold;
  logic             act_en;
  logic             period_end;

  sck_cfg_reg #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
  ) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_we),
    .wr_data    (cfg_wdata),
    .period_end (period_end),
    .act_lo     (act_lo),
    .act_hi     (act_hi),
    .act_hold   (act_hold),
    .act_en     (act_en)
  );

  sck_phase_ctr #(
    .CNT_W (CNT_W)
  ) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .en         (act_en),
    .lo         (act_lo),
    .hi         (act_hi),
    .sclk       (sclk_o),
    .tick       (rise_o),
    .period_end (period_end)
  );

  assign hold_o = act_hold;

  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> (sclk_o && !$past(sclk_o))); // R4

  AST_RISE_HAS_TICK: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && !$past(sclk_o)) |-> rise_o); // R4

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!act_en && !sclk_o) |=> !rise_o); // R5

endmodule

// File: tb/sensor_clk_synth_tb.sv
`timescale 1ns/1ps
module sensor_clk_synth_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        sclk_o, rise_o;
  logic [7:0]  hold_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sensor_clk_synth u_dut (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .sclk_o    (sclk_o),
    .rise_o    (rise_o),
    .hold_o    (hold_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int lo, input int hi, input int hold,
                                     input bit en, input logic [6:0] junk);
    return {junk, en, hold[7:0], hi[7:0], lo[7:0]};
  endfunction

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = 32'hFFFF_FFFF;
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!rise_o) @(negedge clk);
  endtask

  // Measures one full high+low period starting at a tick.
  task automatic measure(input int lo, input int hi, input string req);
    int h;
    int l;
    repeat (3) wait_tick();
    h = 0;
    while (sclk_o) begin h++; @(negedge clk); end
    l = 0;
    while (!rise_o) begin l++; @(negedge clk); end
    chk(h == hi + 1, {req, " high phase"}, h, hi + 1);
    chk(l == lo + 1, {req, " low phase"}, l, lo + 1);
    chk(h + l == lo + hi + 2, {req, " period"}, h + l, lo + hi + 2);
  endtask

  // Per-cycle tick check (R4) and phase-length watch for reload tests (R6).
  bit trans_mode = 0;
  int a_lo, b_lo, a_hi, b_hi;
  bit prev_s = 0;
  int run = 0;
  always @(negedge clk) begin
    if (rst) begin
      prev_s = 0;
      run = 0;
    end else begin
      chk(rise_o == (sclk_o && !prev_s), "R4 tick vs rising edge", rise_o, sclk_o && !prev_s);
      if (sclk_o == prev_s) run++;
      else begin
        if (trans_mode) begin
          if (prev_s) chk(run == a_hi || run == b_hi, "R6 high phase length", run, b_hi);
          else        chk(run == a_lo || run == b_lo, "R6 low phase length", run, b_lo);
        end
        run = 1;
      end
      prev_s = sclk_o;
    end
  end

  initial begin
    #(20ns * 190000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(sclk_o == 0, "R8 sclk after reset", sclk_o, 0);
    chk(rise_o == 0, "R8 tick after reset", rise_o, 0);
    chk(hold_o == 0, "R8 hold after reset", hold_o, 0);
    repeat (20) @(negedge clk);
    chk(sclk_o == 0, "R8 stays disabled", sclk_o, 0);

    // R3 sweep of keys with derived split
    for (int key = 0; key < 48; key++) begin
      wr(mk((key + 1) >> 1, key >> 1, key, 1'b1, 7'h00));
      measure((key + 1) >> 1, key >> 1, "R3 key sweep");
    end
    // R3 max ratio 512
    wr(mk(255, 255, 9, 1'b1, 7'h00));
    measure(255, 255, "R3 max ratio");

    // R2 unequal pairs; R1 junk in upper bits ignored
    wr(mk(0, 5, 1, 1'b1, 7'h7F));
    measure(0, 5, "R2 R1 lo0 hi5");
    wr(mk(9, 0, 2, 1'b1, 7'h2A));
    measure(9, 0, "R2 R1 lo9 hi0");
    wr(mk(3, 200, 3, 1'b1, 7'h55));
    measure(3, 200, "R2 lo3 hi200");

    // R7 hold visible and period unaffected
    wr(mk(4, 6, 8'hA5, 1'b1, 7'h00));
    measure(4, 6, "R7 period with hold A5");
    chk(hold_o == 8'hA5, "R7 hold output", hold_o, 8'hA5);
    wr(mk(4, 6, 8'h3C, 1'b1, 7'h00));
    measure(4, 6, "R7 period with hold 3C");
    chk(hold_o == 8'h3C, "R7 hold output", hold_o, 8'h3C);

    // R6 write during high phase
    wr(mk(7, 5, 0, 1'b1, 7'h00));
    measure(7, 5, "R6 base");
    a_lo = 8; a_hi = 6; b_lo = 3; b_hi = 4;
    wait_tick();
    repeat (2) @(negedge clk);
    trans_mode = 1;
    wr(mk(2, 3, 0, 1'b1, 7'h00));
    repeat (80) @(negedge clk);
    trans_mode = 0;
    measure(2, 3, "R6 after high-phase write");
    // R6 write during low phase
    a_lo = 3; a_hi = 4; b_lo = 8; b_hi = 6;
    wait_tick();
    repeat (6) @(negedge clk);
    trans_mode = 1;
    wr(mk(7, 5, 0, 1'b1, 7'h00));
    repeat (80) @(negedge clk);
    trans_mode = 0;
    measure(7, 5, "R6 after low-phase write");

    // R5 disable: quiet output
    wr(mk(4, 2, 8'h11, 1'b0, 7'h00));
    repeat (30) @(negedge clk);
    begin
      int bad = 0;
      for (int i = 0; i < 200; i++) begin
        if (sclk_o || rise_o) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R5 disabled output quiet", bad, 0);
    end
    chk(hold_o == 8'h11, "R7 hold follows idle word", hold_o, 8'h11);

    // R5 enable latency from idle: rise on edge E+lo+2
    begin
      int cnt = 1;
      int first_hi = 0;
      wr(mk(4, 2, 0, 1'b1, 7'h00));
      while (cnt < 20 && first_hi == 0) begin
        if (sclk_o) first_hi = cnt;
        cnt++;
        if (first_hi == 0) @(negedge clk);
      end
      chk(first_hi == 4 + 3, "R5 first rise cycle", first_hi, 4 + 3);
      chk(rise_o == 1, "R5 tick at first rise", rise_o, 1);
    end

    // R5 ratio-2 start from idle after disable
    wr(mk(0, 0, 0, 1'b0, 7'h00));
    repeat (20) @(negedge clk);
    chk(sclk_o == 0, "R5 disabled low", sclk_o, 0);
    wr(mk(0, 0, 0, 1'b1, 7'h00));
    measure(0, 0, "R5 R3 ratio 2 after enable");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule